// File: doc/BRIEF.md
# Key-Protected Control Register Bank

This block is a bank of 32-bit control and status words behind a simple word-addressed bus. The bus has a valid strobe, a write flag, a byte address and write data. Each word sits at a byte offset inside a window of 2^ADDR_W bytes, and the word index is the address with its two low bits removed. Every access completes in one cycle. A read returns its data on a registered output in the cycle after the request.

Most of the lower words are guarded by a key word at offset 0x00. Software unlocks the bank by writing a parameterised magic value there, and any other value locks it again.

The bank also holds:
- a strap word at 0x70. In the newer-revision mode, writes set its bits, and the revision word at 0x7C acts as a clear-alias for it.
- a set of words that software cannot write.
- a random-data word at 0x78, backed by a 32-bit Galois LFSR that steps on every read of that word.
- a write-only wake-up enable word at 0xC0. Reading it returns its contents and raises a one-cycle access-error pulse.

All reset contents come from parameters or from fixed defaults that depend on the revision mode.

Top module: `ctl_regbank`

## Requirements
- R1: The word index is acc_addr[ADDR_W-1:2], and acc_addr[1:0] is ignored. rd_data updates only in the cycle after a read request and holds its value otherwise.
- R2: A write to offset 0x00 stores 32'd1 when acc_wdata equals MAGIC_KEY and 32'd0 for any other value. A read of 0x00 returns that stored 1 or 0.
- R3: While the key word is zero, writes to offsets 0x004 through 0x100 leave the bank unchanged. Offsets 0x104 and above accept writes whether the bank is locked or not.
- R4: An index at or above NUM_REGS reads as 32'd0, and writes to it change nothing.
- R5: Writes to offsets 0x14, 0x50 to 0x6C, 0x78, 0xE0 and 0xE4 are ignored, so these words keep their reset contents.
- R6: With NEWER_MODE=1, a write to 0x70 ORs acc_wdata into the strap word. A write to 0x7C clears the strap bits that are set in acc_wdata and leaves the revision word unchanged.
- R7: With NEWER_MODE=0, a write to 0x70 replaces the strap word, and a write to 0x7C is ignored.
- R8: Each read of 0x78 steps the LFSR once, with next = (s >> 1) ^ (s[0] ? RNG_POLY : 0) starting from RNG_SEED, and returns the new state. The contents of 0x74 have no effect on this.
- R9: After reset, the words hold these values:
  - 0x00 = KEY_INIT, 0x70 = STRAP_A_INIT, 0xD0 = STRAP_B_INIT, 0x7C = REV_ID
  - 0x3C = 1, 0x74 = 0xE, 0xE0 = 0xE4 = 0xFF
  - 0x24 = 0x93000400 when NEWER_MODE=1, or 0x291 when NEWER_MODE=0
  - 0x9C = 0x023FFFF3 when NEWER_MODE=1, or 0x003FFFF3 when NEWER_MODE=0
  - every other word = 0
  
  rd_data and acc_err are 0 after reset.
- R10: A read of 0xC0 returns its stored contents. acc_err is 1 in exactly the cycle that this rd_data is presented, and 0 in every other cycle.
- R11: An allowed write to any other word in range stores acc_wdata unchanged, and a later read returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_vld | input | 1 | Access request in this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address inside the window |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| acc_err | output | 1 | One-cycle pulse on a read of the write-only word |

## Verification
The assertions assume the following about the bus:
- at most one request per cycle;
- known values on acc_vld and acc_wr;
- no request during the two cycles in which the internal reset is still being released.

They also assume NUM_REGS fits inside the window. The stimulus holds off every access until several cycles after reset is released, and it issues one request per clock from tasks. It uses a nonzero low address pair in only one read, which checks that those bits are ignored. Back-to-back reads of the random word are issued on purpose, so that the adjacent-value property is exercised.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_STORE,
    OP_OR,
    OP_CLR,
    OP_KEY
  } wr_op_e;

  // word indexes (byte offset >> 2) whose behaviour is special
  localparam int unsigned IX_KEY        = 0;
  localparam int unsigned IX_PLL_H      = 9;
  localparam int unsigned IX_RST_STAT   = 15;
  localparam int unsigned IX_CNT_EVAL   = 5;
  localparam int unsigned IX_SCR_LO     = 20;
  localparam int unsigned IX_SCR_HI     = 27;
  localparam int unsigned IX_STRAP_A    = 28;
  localparam int unsigned IX_RNG_CTL    = 29;
  localparam int unsigned IX_RNG        = 30;
  localparam int unsigned IX_REV        = 31;
  localparam int unsigned IX_WDOG_CTL   = 39;
  localparam int unsigned IX_WAKE       = 48;
  localparam int unsigned IX_STRAP_B    = 52;
  localparam int unsigned IX_FREE_LO    = 56;
  localparam int unsigned IX_FREE_HI    = 57;
  localparam int unsigned IX_OPEN_FIRST = 65;

  function automatic logic [31:0] dflt_word(input int unsigned ix, input logic newer);
    case (ix)
      IX_PLL_H:              dflt_word = newer ? 32'h9300_0400 : 32'h0000_0291;
      IX_RST_STAT:           dflt_word = 32'h0000_0001;
      IX_RNG_CTL:            dflt_word = 32'h0000_000E;
      IX_WDOG_CTL:           dflt_word = newer ? 32'h023F_FFF3 : 32'h003F_FFF3;
      IX_FREE_LO, IX_FREE_HI: dflt_word = 32'h0000_00FF;
      default:               dflt_word = 32'h0;
    endcase
  endfunction

  function automatic logic is_ro(input int unsigned ix);
    is_ro = (ix == IX_CNT_EVAL) || (ix >= IX_SCR_LO && ix <= IX_SCR_HI) ||
            (ix == IX_RNG) || (ix == IX_FREE_LO) || (ix == IX_FREE_HI);
  endfunction

  function automatic logic [31:0] lfsr_step(input logic [31:0] s, input logic [31:0] poly);
    lfsr_step = (s >> 1) ^ (s[0] ? poly : 32'h0);
  endfunction

endpackage

// File: rtl/ctl_regbank_rst.sv
module ctl_regbank_rst (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/ctl_regbank_rng.sv
module ctl_regbank_rng
  import ctl_regbank_pkg::*;
#(
  parameter logic [31:0] SEED = 32'hC0DE_5EED,
  parameter logic [31:0] POLY = 32'h8020_0003
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  output logic [31:0] st_q,
  output logic [31:0] st_nxt
);
  always_comb st_nxt = lfsr_step(st_q, POLY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= SEED;
    else if (adv) st_q <= st_nxt;
  end
endmodule

// File: rtl/ctl_regbank_dec.sv
module ctl_regbank_dec
  import ctl_regbank_pkg::*;
#(
  parameter int unsigned IDX_W      = 10,
  parameter int unsigned NUM_REGS   = 106,
  parameter bit          NEWER_MODE = 1'b1
) (
  input  logic             acc_vld,
  input  logic             acc_wr,
  input  logic [IDX_W-1:0] idx,
  input  logic             key_open,
  output wr_op_e           op,
  output logic [IDX_W-1:0] tgt,
  output logic             rd_en,
  output logic             rnd_adv,
  output logic             wake_rd,
  output logic             oob
);
  logic in_rng, guarded, wr_ok;

  assign in_rng  = 32'(idx) < NUM_REGS;
  assign oob     = !in_rng;
  assign guarded = (idx != '0) && (32'(idx) < IX_OPEN_FIRST);
  assign wr_ok   = acc_vld && acc_wr && in_rng && !(guarded && !key_open);
  assign rd_en   = acc_vld && !acc_wr;
  assign rnd_adv = rd_en && in_rng && (idx == IDX_W'(IX_RNG));
  assign wake_rd = rd_en && in_rng && (idx == IDX_W'(IX_WAKE));

  always_comb begin
    op  = OP_NONE;
    tgt = idx;
    if (wr_ok) begin
      if (idx == IDX_W'(IX_KEY)) begin
        op = OP_KEY;
      end else if (idx == IDX_W'(IX_STRAP_A)) begin
        op = NEWER_MODE ? OP_OR : OP_STORE;
      end else if (idx == IDX_W'(IX_REV)) begin
        if (NEWER_MODE) begin
          op  = OP_CLR;
          tgt = IDX_W'(IX_STRAP_A);
        end
      end else if (!is_ro(32'(idx))) begin
        op = OP_STORE;
      end
    end
  end
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import ctl_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned NUM_REGS     = 106,
  parameter bit          NEWER_MODE   = 1'b1,
  parameter logic [31:0] MAGIC_KEY    = 32'h5EC0_0B1D,
  parameter logic [31:0] KEY_INIT     = 32'h0,
  parameter logic [31:0] STRAP_A_INIT = 32'h0000_0F00,
  parameter logic [31:0] STRAP_B_INIT = 32'h1234_0000,
  parameter logic [31:0] REV_ID       = 32'h0403_0303,
  parameter logic [31:0] RNG_SEED     = 32'hC0DE_5EED,
  parameter logic [31:0] RNG_POLY     = 32'h8020_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_vld,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       rd_data,
  output logic              acc_err
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             rst_q_n;
  logic [IDX_W-1:0] idx;
  logic [1:0]       unused_lo;
  wr_op_e           op;
  logic [IDX_W-1:0] tgt;
  logic             rd_en, rnd_adv, wake_rd, oob;
  logic [31:0]      rng_q, rng_nxt;
  logic [31:0]      word_q [NUM_REGS];
  logic [31:0]      key_word, strap_word;
  logic [31:0]      rd_word, rd_d, rd_q;
  logic             err_q;

  assign idx       = acc_addr[ADDR_W-1:2];
  assign unused_lo = acc_addr[1:0];

  ctl_regbank_rst u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  ctl_regbank_dec #(.IDX_W(IDX_W), .NUM_REGS(NUM_REGS), .NEWER_MODE(NEWER_MODE)) u_dec (
    .acc_vld(acc_vld), .acc_wr(acc_wr), .idx(idx), .key_open(key_word != 32'h0),
    .op(op), .tgt(tgt), .rd_en(rd_en), .rnd_adv(rnd_adv), .wake_rd(wake_rd), .oob(oob)
  );

  ctl_regbank_rng #(.SEED(RNG_SEED), .POLY(RNG_POLY)) u_rng (
    .clk(clk), .rst_n(rst_q_n), .adv(rnd_adv), .st_q(rng_q), .st_nxt(rng_nxt)
  );

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_word
    localparam logic [31:0] RST_VAL =
      (gi == IX_KEY)     ? KEY_INIT     :
      (gi == IX_STRAP_A) ? STRAP_A_INIT :
      (gi == IX_STRAP_B) ? STRAP_B_INIT :
      (gi == IX_REV)     ? REV_ID       : dflt_word(gi, NEWER_MODE);

    logic        en;
    logic [31:0] cur, nxt;

    assign en = (op != OP_NONE) && (tgt == IDX_W'(gi));

    always_comb begin
      case (op)
        OP_STORE: nxt = acc_wdata;
        OP_OR:    nxt = cur | acc_wdata;
        OP_CLR:   nxt = cur & ~acc_wdata;
        OP_KEY:   nxt = {31'h0, acc_wdata == MAGIC_KEY};
        default:  nxt = cur;
      endcase
    end

    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) cur <= RST_VAL;
      else if (en)  cur <= nxt;
    end

    assign word_q[gi] = cur;
  end

  assign key_word   = word_q[IX_KEY];
  assign strap_word = word_q[IX_STRAP_A];

  always_comb begin
    rd_word = 32'h0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx == IDX_W'(i)) rd_word = word_q[i];
    end
  end

  always_comb begin
    if (oob)          rd_d = 32'h0;
    else if (rnd_adv) rd_d = rng_nxt;
    else              rd_d = rd_word;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rd_q  <= 32'h0;
      err_q <= 1'b0;
    end else begin
      err_q <= wake_rd;
      if (rd_en) rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;
  assign acc_err = err_q;
endmodule

// File: rtl/ctl_regbank_chk.sv
module ctl_regbank_chk
  import ctl_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_REGS  = 106,
  parameter logic [31:0] MAGIC_KEY = 32'h5EC0_0B1D
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_vld,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [31:0]       acc_wdata,
  input logic [31:0]       rd_data,
  input logic              acc_err,
  input logic [31:0]       key_word,
  input logic [31:0]       strap_word
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] c_idx;
  logic [1:0]       unused_c_lo;
  logic             c_rd, c_wr;

  assign c_idx       = acc_addr[ADDR_W-1:2];
  assign unused_c_lo = acc_addr[1:0];
  assign c_rd        = acc_vld && !acc_wr;
  assign c_wr        = acc_vld && acc_wr;

  p_rd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !c_rd |=> $stable(rd_data));

  p_key_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr && c_idx == '0 && acc_wdata == MAGIC_KEY) |=> key_word == 32'd1);

  p_key_shut_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr && c_idx == '0 && acc_wdata != MAGIC_KEY) |=> key_word == 32'd0);

  p_lock_strap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr && key_word == 32'h0 && c_idx != '0 && 32'(c_idx) < IX_OPEN_FIRST)
      |=> $stable(strap_word));

  p_oob_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && 32'(c_idx) >= NUM_REGS) |=> rd_data == 32'h0);

  p_rng_fresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && c_idx == IDX_W'(IX_RNG)) ##1 (c_rd && c_idx == IDX_W'(IX_RNG))
      |=> rd_data != $past(rd_data));

  p_err_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(c_rd && c_idx == IDX_W'(IX_WAKE)));

  p_err_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && c_idx == IDX_W'(IX_WAKE)) |=> acc_err);
endmodule

bind ctl_regbank ctl_regbank_chk #(
  .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .MAGIC_KEY(MAGIC_KEY)
) u_chk (
  .clk(clk), .rst_n(rst_q_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
  .acc_err(acc_err), .key_word(key_word), .strap_word(strap_word)
);

// File: tb/test_ctl_regbank.sv
module test_ctl_regbank;
  localparam int          NREG    = 106;
  localparam logic [31:0] MAGIC   = 32'h5EC0_0B1D;
  localparam logic [31:0] SEED    = 32'hC0DE_5EED;
  localparam logic [31:0] POLY    = 32'h8020_0003;
  localparam logic [31:0] ST_A    = 32'h0000_0F00;
  localparam logic [31:0] ST_B    = 32'h1234_0000;
  localparam logic [31:0] REV_NEW = 32'h0403_0303;
  localparam logic [31:0] REV_OLD = 32'h0202_0303;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_vld, acc_wr;
  logic [11:0] acc_addr;
  logic [31:0] acc_wdata;
  logic [31:0] rd_new, rd_old;
  logic        err_new, err_old;

  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R9";

  logic [31:0] mreg [2][NREG];
  logic [31:0] mrng [2];
  logic [31:0] exp_rd [2];
  logic        exp_err [2];
  logic [31:0] b_rng;

  always #2 clk = ~clk;

  ctl_regbank #(.NEWER_MODE(1'b1), .MAGIC_KEY(MAGIC), .KEY_INIT(32'h0), .STRAP_A_INIT(ST_A),
    .STRAP_B_INIT(ST_B), .REV_ID(REV_NEW), .RNG_SEED(SEED), .RNG_POLY(POLY)) i_ctl_regbank (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .rd_data(rd_new), .acc_err(err_new));

  ctl_regbank #(.NEWER_MODE(1'b0), .MAGIC_KEY(MAGIC), .KEY_INIT(32'h0), .STRAP_A_INIT(ST_A),
    .STRAP_B_INIT(ST_B), .REV_ID(REV_OLD), .RNG_SEED(SEED), .RNG_POLY(POLY)) i_ctl_regbank_legacy (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .rd_data(rd_old), .acc_err(err_old));

  function automatic logic [31:0] nstep(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? POLY : 32'h0);
  endfunction

  // reset contents per R9; m = 1 is the newer mode
  function automatic logic [31:0] rst_val(input int m, input int ix);
    case (ix)
      0:  return 32'h0;
      28: return ST_A;
      52: return ST_B;
      31: return m ? REV_NEW : REV_OLD;
      15: return 32'h1;
      29: return 32'hE;
      56: return 32'hFF;
      57: return 32'hFF;
      9:  return m ? 32'h9300_0400 : 32'h0000_0291;
      39: return m ? 32'h023F_FFF3 : 32'h003F_FFF3;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit no_write(input int ix);
    return ix == 5 || (ix >= 20 && ix <= 27) || ix == 30 || ix == 56 || ix == 57;
  endfunction

  // behavioural reference, one step per clock
  always @(posedge clk) begin
    for (int m = 0; m < 2; m++) begin
      if (!rst_n) begin
        for (int i = 0; i < NREG; i++) mreg[m][i] = rst_val(m, i);
        mrng[m] = SEED; exp_rd[m] = 32'h0; exp_err[m] = 1'b0;
      end else begin
        int ix;
        ix = int'(acc_addr[11:2]);
        exp_err[m] = 1'b0;
        if (acc_vld && !acc_wr) begin
          if (ix >= NREG) exp_rd[m] = 32'h0;
          else if (ix == 30) begin mrng[m] = nstep(mrng[m]); exp_rd[m] = mrng[m]; end
          else exp_rd[m] = mreg[m][ix];
          exp_err[m] = (ix == 48);
        end else if (acc_vld && acc_wr && ix < NREG &&
                     !(ix >= 1 && ix <= 64 && mreg[m][0] == 32'h0)) begin
          if (ix == 0) mreg[m][0] = (acc_wdata == MAGIC) ? 32'd1 : 32'd0;
          else if (ix == 28) mreg[m][28] = m ? (mreg[m][28] | acc_wdata) : acc_wdata;
          else if (ix == 31) begin if (m) mreg[m][28] = mreg[m][28] & ~acc_wdata; end
          else if (!no_write(ix)) mreg[m][ix] = acc_wdata;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int m = 0; m < 2; m++) begin
        n_chk++;
        if ((m ? rd_new : rd_old) !== exp_rd[m] || (m ? err_new : err_old) !== exp_err[m]) begin
          n_fail++;
          $display("FAIL %s model mode=%0d rd=%h err=%b expected rd=%h err=%b", cur_req, m,
                   m ? rd_new : rd_old, m ? err_new : err_old, exp_rd[m], exp_err[m]);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    acc_vld = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_vld = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    acc_vld = 1'b1; acc_wr = 1'b0; acc_addr = a;
    @(negedge clk);
    acc_vld = 1'b0;
  endtask

  task automatic rd2(input string req, input logic [11:0] a, input logic [31:0] en, input logic [31:0] eo);
    rd(a);
    chk(req, rd_new, en);
    chk(req, rd_old, eo);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (R1) got=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; acc_vld = 1'b0; acc_wr = 1'b0; acc_addr = '0; acc_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    cur_req = "R9";
    chk("R9 rd_data", rd_new, 32'h0);
    chk("R9 acc_err", {31'h0, err_new}, 32'h0);
    rd2("R9 key", 12'h000, 32'h0, 32'h0);
    rd2("R9 0x3C", 12'h03C, 32'h1, 32'h1);
    rd2("R9 0x74", 12'h074, 32'hE, 32'hE);
    rd2("R9 strapA", 12'h070, ST_A, ST_A);
    rd2("R9 strapB", 12'h0D0, ST_B, ST_B);
    rd2("R9 rev", 12'h07C, REV_NEW, REV_OLD);
    rd2("R9 0x24", 12'h024, 32'h9300_0400, 32'h0000_0291);
    rd2("R9 0xE0", 12'h0E0, 32'hFF, 32'hFF);

    cur_req = "R3";
    wr(12'h040, 32'hDEAD_BEEF); rd2("R3 locked 0x40", 12'h040, 32'h0, 32'h0);
    wr(12'h100, 32'h33);        rd2("R3 locked 0x100", 12'h100, 32'h0, 32'h0);
    wr(12'h070, 32'hFFFF_FFFF); rd2("R3 locked strap", 12'h070, ST_A, ST_A);
    wr(12'h104, 32'h1111_2222); rd2("R3 open 0x104", 12'h104, 32'h1111_2222, 32'h1111_2222);

    cur_req = "R2";
    wr(12'h000, MAGIC ^ 32'h1); rd2("R2 wrong key", 12'h000, 32'h0, 32'h0);
    wr(12'h000, MAGIC);         rd2("R2 magic key", 12'h000, 32'h1, 32'h1);

    cur_req = "R11";
    wr(12'h040, 32'hDEAD_BEEF); rd2("R11 0x40", 12'h040, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    wr(12'h100, 32'h33);        rd2("R11 0x100", 12'h100, 32'h33, 32'h33);

    cur_req = "R1";
    rd2("R1 low bits", 12'h043, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    wr(12'h044, 32'h7);
    repeat (2) @(negedge clk);
    chk("R1 hold", rd_new, 32'hDEAD_BEEF);

    cur_req = "R5";
    wr(12'h014, 32'hA5A5_A5A5); rd2("R5 0x14", 12'h014, 32'h0, 32'h0);
    wr(12'h050, 32'hA5A5_A5A5); rd2("R5 0x50", 12'h050, 32'h0, 32'h0);
    wr(12'h06C, 32'hA5A5_A5A5); rd2("R5 0x6C", 12'h06C, 32'h0, 32'h0);
    wr(12'h0E0, 32'hA5A5_A5A5); rd2("R5 0xE0", 12'h0E0, 32'hFF, 32'hFF);
    wr(12'h0E4, 32'hA5A5_A5A5); rd2("R5 0xE4", 12'h0E4, 32'hFF, 32'hFF);

    cur_req = "R6/R7";
    wr(12'h070, 32'h0000_00F0);
    rd2("R6 R7 strap write", 12'h070, 32'h0000_0FF0, 32'h0000_00F0);
    wr(12'h07C, 32'h0000_0300);
    rd2("R6 R7 strap clear", 12'h070, 32'h0000_0CF0, 32'h0000_00F0);
    rd2("R6 R7 rev kept", 12'h07C, REV_NEW, REV_OLD);

    cur_req = "R8";
    b_rng = SEED;
    b_rng = nstep(b_rng); rd2("R8 first", 12'h078, b_rng, b_rng);
    wr(12'h074, 32'h0);
    b_rng = nstep(b_rng); rd2("R8 ctl cleared", 12'h078, b_rng, b_rng);
    wr(12'h078, 32'h0);
    b_rng = nstep(b_rng); rd2("R8 write ignored", 12'h078, b_rng, b_rng);
    acc_vld = 1'b1; acc_wr = 1'b0; acc_addr = 12'h078;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      b_rng = nstep(b_rng);
      chk("R8 back-to-back", rd_new, b_rng);
    end
    acc_vld = 1'b0;

    cur_req = "R10";
    wr(12'h0C0, 32'h0000_BEEF);
    rd2("R10 wake data", 12'h0C0, 32'h0000_BEEF, 32'h0000_BEEF);
    chk("R10 err pulse", {31'h0, err_new}, 32'h1);
    @(negedge clk);
    chk("R10 err drop", {31'h0, err_new}, 32'h0);

    cur_req = "R4";
    rd2("R4 beyond read", 12'h1A8, 32'h0, 32'h0);
    wr(12'h1A8, 32'h5); rd2("R4 beyond write", 12'h1A8, 32'h0, 32'h0);
    rd2("R4 top of window", 12'hFFC, 32'h0, 32'h0);

    cur_req = "R2/R3";
    wr(12'h000, 32'h0);         rd2("R2 relock", 12'h000, 32'h0, 32'h0);
    wr(12'h040, 32'h1);         rd2("R3 relocked", 12'h040, 32'hDEAD_BEEF, 32'hDEAD_BEEF);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule